// File: doc/BRIEF.md
# Packed SIMD Equality Mask Unit

This unit compares two packed vector operands element by element and returns a full-width mask. A result element is all ones where its two source elements match and all zeros where they differ. An 8-bit selector sets the element size to 8, 16 or 32 bits. A 2-bit width mode sets how many low bits take part in the compare: 64, 128 or 256. The width mode also sets what the result holds above the active width.

In the two 128-bit forms, the result bits above 127 are either kept from the previous destination value or forced to zero. In the 64-bit form, every bit above 63 is kept. The 256-bit form runs the same compare on each 128-bit half, and no element crosses the boundary between the halves. A selector value that names no element size produces no compare. In that case the unit returns the previous destination unchanged and raises an illegal flag.

The result is registered, so it appears one cycle after `in_valid`. There is no back-pressure. The caller drives the first source, the second source and the old destination value. In a two-operand use the first source and the old destination are normally the same register.

Top module: `simd_eq_cmp`

## Requirements
- R1: With `sel` = 8'h74 the elements are bytes. Each result byte is 8'hFF when the matching bytes of `src_a` and `src_b` are equal, and 8'h00 otherwise.
- R2: With `sel` = 8'h75 the elements are 16-bit words. Each result word is 16'hFFFF when the pair is equal, and 16'h0000 otherwise.
- R3: With `sel` = 8'h76 the elements are 32-bit doublewords. Each result doubleword is all ones when the pair is equal, and all zeros otherwise.
- R4: With `width_mode` = 2'b00, only bits 63:0 are compared. Result bits 255:64 equal `old_dst[255:64]`.
- R5: With `width_mode` = 2'b01, bits 127:0 are compared. Result bits 255:128 equal `old_dst[255:128]`.
- R6: With `width_mode` = 2'b10, bits 127:0 are compared. Result bits 255:128 are zero.
- R7: With `width_mode` = 2'b11, all 256 bits are compared. Each 128-bit half is handled on its own, so a difference in one element clears only that element.
- R8: A `sel` value other than 8'h74, 8'h75 or 8'h76 raises `out_illegal` in the same cycle as `out_valid`. In that case `out_mask` equals `old_dst` in full, whatever the width mode.
- R9: `out_valid` is high exactly one cycle after a cycle with `in_valid` high, and low otherwise. When `in_valid` is low, `out_mask` holds its value.
- R10: A synchronous active-high `rst` clears `out_valid`, `out_illegal` and `out_mask` at the next edge. It takes priority over `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request this cycle |
| sel | input | 8 | Element size selector (8'h74 byte, 8'h75 word, 8'h76 doubleword) |
| width_mode | input | 2 | 00: 64-bit keep upper, 01: 128-bit keep upper, 10: 128-bit zero upper, 11: 256-bit |
| src_a | input | 256 | First source operand |
| src_b | input | 256 | Second source operand |
| old_dst | input | 256 | Previous destination value |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_illegal | output | 1 | Selector was not a legal element size |
| out_mask | output | 256 | Equality mask merged with the kept or zeroed upper bits |

## Verification
The bench builds the unit with its default parameters: a 256-bit vector, 128-bit lanes and a 64-bit narrow width. At this size every pairing of width mode and element size can be swept in full.

Each pairing is driven with four kinds of data:
- independent random operands;
- identical operands;
- operands that are equal except in scattered random elements;
- operands that differ only in the top bit of the highest active element.

The last kind reaches the element that sits just under each width boundary and the 128-bit split. Illegal selector codes on both sides of the legal range are tried in every width mode.

// File: rtl/simd_eq_pkg.sv
package simd_eq_pkg;

    localparam logic [7:0] SEL_BYTE  = 8'h74;
    localparam logic [7:0] SEL_WORD  = 8'h75;
    localparam logic [7:0] SEL_DWORD = 8'h76;

    typedef enum logic [1:0] {
        ESZ_B   = 2'd0,
        ESZ_W   = 2'd1,
        ESZ_D   = 2'd2,
        ESZ_BAD = 2'd3
    } esize_e;

    typedef enum logic [1:0] {
        WM_64_KEEP  = 2'b00,
        WM_128_KEEP = 2'b01,
        WM_128_ZERO = 2'b10,
        WM_FULL     = 2'b11
    } wmode_e;

    function automatic esize_e decode_size(input logic [7:0] code);
        case (code)
            SEL_BYTE:  return ESZ_B;
            SEL_WORD:  return ESZ_W;
            SEL_DWORD: return ESZ_D;
            default:   return ESZ_BAD;
        endcase
    endfunction

endpackage

// File: rtl/simd_eq_lane.sv
// One lane of equality compare; byte matches are combined into word or
// doubleword matches, so no element can cross the lane edge.
module simd_eq_lane
    import simd_eq_pkg::*;
#(
    parameter int LANE_W = 128
) (
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    input  esize_e            esz,
    output logic [LANE_W-1:0] mask
);
    localparam int NB = LANE_W / 8;

    logic [NB-1:0] beq;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        localparam int W0 = (i / 2) * 2;
        localparam int D0 = (i / 4) * 4;
        logic grp;

        assign beq[i] = (a[i*8 +: 8] == b[i*8 +: 8]);

        always_comb begin
            case (esz)
                ESZ_B:   grp = beq[i];
                ESZ_W:   grp = &beq[W0 +: 2];
                ESZ_D:   grp = &beq[D0 +: 4];
                default: grp = 1'b0;
            endcase
        end

        assign mask[i*8 +: 8] = {8{grp}};
    end
endmodule

// File: rtl/simd_eq_span.sv
// Decides, per narrow chunk, whether the chunk takes the compare result,
// is forced to zero, or keeps the old destination.
module simd_eq_span
    import simd_eq_pkg::*;
#(
    parameter int VEC_W    = 256,
    parameter int MID_W    = 128,
    parameter int NARROW_W = 64
) (
    input  wmode_e                    wmode,
    output logic [VEC_W/NARROW_W-1:0] act,
    output logic [VEC_W/NARROW_W-1:0] zero
);
    localparam int N_CH  = VEC_W / NARROW_W;
    localparam int N_MID = MID_W / NARROW_W;

    int n_act;

    always_comb begin
        case (wmode)
            WM_64_KEEP:  n_act = 1;
            WM_128_KEEP: n_act = N_MID;
            WM_128_ZERO: n_act = N_MID;
            default:     n_act = N_CH;
        endcase
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_chunk
        assign act[c]  = (c < n_act);
        assign zero[c] = !act[c] && (wmode == WM_128_ZERO);
    end
endmodule

// File: rtl/simd_eq_cmp.sv
module simd_eq_cmp
    import simd_eq_pkg::*;
#(
    parameter int VEC_W    = 256,
    parameter int MID_W    = 128,
    parameter int NARROW_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       sel,
    input  logic [1:0]       width_mode,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [VEC_W-1:0] old_dst,
    output logic             out_valid,
    output logic             out_illegal,
    output logic [VEC_W-1:0] out_mask
);
    localparam int NUM_LANES  = VEC_W / MID_W;
    localparam int NUM_CHUNKS = VEC_W / NARROW_W;

    typedef struct packed {
        logic             valid;
        logic             illegal;
        logic [VEC_W-1:0] mask;
    } state_t;

    esize_e                esz;
    wmode_e                wm;
    logic                  legal;
    logic [VEC_W-1:0]      cmp_mask;
    logic [NUM_CHUNKS-1:0] chunk_act;
    logic [NUM_CHUNKS-1:0] chunk_zero;
    state_t                st_d;
    state_t                st_q;

    assign esz   = decode_size(sel);
    assign wm    = wmode_e'(width_mode);
    assign legal = (esz != ESZ_BAD);

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        simd_eq_lane #(.LANE_W(MID_W)) u_lane (
            .a    (src_a[l*MID_W +: MID_W]),
            .b    (src_b[l*MID_W +: MID_W]),
            .esz  (esz),
            .mask (cmp_mask[l*MID_W +: MID_W])
        );
    end

    simd_eq_span #(
        .VEC_W    (VEC_W),
        .MID_W    (MID_W),
        .NARROW_W (NARROW_W)
    ) u_span (
        .wmode (wm),
        .act   (chunk_act),
        .zero  (chunk_zero)
    );

    always_comb begin
        st_d         = st_q;
        st_d.valid   = in_valid;
        st_d.illegal = in_valid && !legal;
        if (in_valid) begin
            for (int c = 0; c < NUM_CHUNKS; c++) begin
                if (!legal) begin
                    st_d.mask[c*NARROW_W +: NARROW_W] = old_dst[c*NARROW_W +: NARROW_W];
                end else if (chunk_act[c]) begin
                    st_d.mask[c*NARROW_W +: NARROW_W] = cmp_mask[c*NARROW_W +: NARROW_W];
                end else if (chunk_zero[c]) begin
                    st_d.mask[c*NARROW_W +: NARROW_W] = '0;
                end else begin
                    st_d.mask[c*NARROW_W +: NARROW_W] = old_dst[c*NARROW_W +: NARROW_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign out_illegal = st_q.illegal;
    assign out_mask    = st_q.mask;
endmodule

// File: rtl/simd_eq_cmp_chk.sv
module simd_eq_cmp_chk
    import simd_eq_pkg::*;
#(
    parameter int VEC_W = 256
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [7:0]       sel,
    input logic [1:0]       width_mode,
    input logic [VEC_W-1:0] src_a,
    input logic [VEC_W-1:0] src_b,
    input logic [VEC_W-1:0] old_dst,
    input logic             out_valid,
    input logic             out_illegal,
    input logic [VEC_W-1:0] out_mask
);
    logic legal_in;
    assign legal_in = (sel == SEL_BYTE) || (sel == SEL_WORD) || (sel == SEL_DWORD);

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R9
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R9
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_mask));

    // R8
    illegal_pair_chk: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> out_valid);

    // R8
    illegal_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !legal_in) |=> (out_illegal && out_mask == $past(old_dst)));

    // R6
    zero_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && legal_in && width_mode == 2'b10) |=> (out_mask[VEC_W-1:128] == '0));

    // R4
    keep_upper64_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && legal_in && width_mode == 2'b00)
            |=> (out_mask[VEC_W-1:64] == $past(old_dst[VEC_W-1:64])));

    // R1
    all_match_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sel == SEL_BYTE && width_mode == 2'b11 && src_a == src_b) |=> (&out_mask));

    // R3
    dword_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sel == SEL_DWORD && src_a[31:0] != src_b[31:0]) |=> (out_mask[31:0] == '0));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_illegal));
endmodule

bind simd_eq_cmp simd_eq_cmp_chk #(.VEC_W(VEC_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .sel         (sel),
    .width_mode  (width_mode),
    .src_a       (src_a),
    .src_b       (src_b),
    .old_dst     (old_dst),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .out_mask    (out_mask)
);

// File: tb/simd_eq_cmp_tb_top.sv
`timescale 1ns/1ps
module simd_eq_cmp_tb_top;
    localparam int VW = 256;
    localparam int WD_CYCLES = 100000;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [7:0]    sel;
    logic [1:0]    width_mode;
    logic [VW-1:0] src_a;
    logic [VW-1:0] src_b;
    logic [VW-1:0] old_dst;
    logic          out_valid;
    logic          out_illegal;
    logic [VW-1:0] out_mask;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    simd_eq_cmp dut_i (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .sel         (sel),
        .width_mode  (width_mode),
        .src_a       (src_a),
        .src_b       (src_b),
        .old_dst     (old_dst),
        .out_valid   (out_valid),
        .out_illegal (out_illegal),
        .out_mask    (out_mask)
    );

    function automatic logic [VW-1:0] rnd256();
        logic [VW-1:0] r;
        for (int i = 0; i < VW/32; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    function automatic int act_width(input logic [1:0] m);
        if (m == 2'b00) return 64;
        if (m == 2'b11) return 256;
        return 128;
    endfunction

    function automatic int elem_size(input logic [7:0] s);
        if (s == 8'h74) return 8;
        if (s == 8'h75) return 16;
        if (s == 8'h76) return 32;
        return 0;
    endfunction

    // Reference: walk every active element bit by bit.
    function automatic logic [VW-1:0] ref_calc(input logic [7:0] s, input logic [1:0] m,
                                               input logic [VW-1:0] a, input logic [VW-1:0] b,
                                               input logic [VW-1:0] old);
        logic [VW-1:0] r;
        int es;
        int aw;
        logic eq;
        es = elem_size(s);
        if (es == 0) return old;
        aw = act_width(m);
        r  = (m == 2'b10) ? '0 : old;
        for (int e = 0; e < aw/es; e++) begin
            eq = 1'b1;
            for (int k = 0; k < es; k++) if (a[e*es+k] !== b[e*es+k]) eq = 1'b0;
            for (int k = 0; k < es; k++) r[e*es+k] = eq;
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [7:0] s, input logic [1:0] m);
        string t;
        case (s)
            8'h74:   t = "R1";
            8'h75:   t = "R2";
            8'h76:   t = "R3";
            default: return "R8";
        endcase
        case (m)
            2'b00:   t = {t, " R4"};
            2'b01:   t = {t, " R5"};
            2'b10:   t = {t, " R6"};
            default: t = {t, " R7"};
        endcase
        return t;
    endfunction

    task automatic check(input string tag, input logic [VW+1:0] got, input logic [VW+1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic do_op(input logic [7:0] s, input logic [1:0] m,
                         input logic [VW-1:0] a, input logic [VW-1:0] b, input logic [VW-1:0] old);
        logic expect_ill;
        @(negedge clk);
        in_valid   = 1'b1;
        sel        = s;
        width_mode = m;
        src_a      = a;
        src_b      = b;
        old_dst    = old;
        @(negedge clk);
        in_valid = 1'b0;
        expect_ill = (elem_size(s) == 0);
        check(tag_of(s, m), {out_valid, out_illegal, out_mask},
              {1'b1, expect_ill, ref_calc(s, m, a, b, old)});
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R9 watchdog expired actual=running expected=finished");
            report();
            $finish;
        end
    end

    initial begin : main
        logic [VW-1:0] a;
        logic [VW-1:0] b;
        logic [VW-1:0] old;
        logic [VW-1:0] held;
        logic [7:0]    bad_sel [4];
        bad_sel[0] = 8'h00;
        bad_sel[1] = 8'h73;
        bad_sel[2] = 8'h77;
        bad_sel[3] = 8'hFF;

        rst = 1'b1; in_valid = 1'b0; sel = 8'h74; width_mode = 2'b11;
        src_a = '0; src_b = '0; old_dst = '0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10", {out_valid, out_illegal, out_mask}, '0);
        rst = 1'b0;

        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 3; s++) begin
                for (int rep = 0; rep < 16; rep++) begin
                    a   = rnd256();
                    old = rnd256();
                    case (rep % 4)
                        0: b = rnd256();
                        1: b = a;
                        2: begin
                            b = a;
                            for (int w = 0; w < VW/32; w++)
                                if ($urandom % 2 == 1) b[w*32 + ($urandom % 32)] ^= 1'b1;
                        end
                        default: begin
                            b = a;
                            b[act_width(2'(m)) - 1] ^= 1'b1;
                        end
                    endcase
                    do_op(8'h74 + 8'(s), 2'(m), a, b, old);
                end
            end
        end

        // R7: difference only in the top element of the lower half
        a = rnd256(); b = a; b[127] ^= 1'b1;
        do_op(8'h76, 2'b11, a, b, rnd256());

        // R8: illegal selectors in every width mode
        for (int m = 0; m < 4; m++)
            for (int k = 0; k < 4; k++)
                do_op(bad_sel[k], 2'(m), rnd256(), rnd256(), rnd256());

        // R9: idle cycles drop valid and hold the mask
        a = rnd256();
        do_op(8'h75, 2'b11, a, a, rnd256());
        held = out_mask;
        src_a = rnd256(); src_b = rnd256(); old_dst = rnd256(); sel = 8'h99;
        repeat (2) @(negedge clk);
        check("R9", {out_valid, out_illegal, out_mask}, {2'b00, held});

        // R10: reset wins over a pending request
        do_op(8'h10, 2'b01, rnd256(), rnd256(), rnd256());
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; sel = 8'h10;
        @(negedge clk);
        check("R10", {out_valid, out_illegal, out_mask}, '0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);

        done = 1;
        report();
        $finish;
    end
endmodule